// File: doc/BRIEF.md
# Interrupt Enable Register with Mask Views

This block holds seven interrupt-enable flags and turns them into a single interrupt request. The flags cover magic-packet wake, system error, receive, transmit, transmit done, transmit start and software timer. Each flag is ANDed with a latched status bit from outside, and the request output is the OR of those products. Software changes the flags through a compact write word: a bitmap selects flags and a single value bit is copied into each selected one. No read-modify-write is needed.

Two older views of the same storage also remain. One is a pair of mask bits of inverted polarity for receive and transmit. The other is a set of per-flag alias strobes of normal polarity for the other five flags. A hard reset and a soft reset load different defaults into the receive and transmit flags. An external configuration preset can make hard reset enable them as well. The block has no data stream, so all pins are plain control and status signals.

Top module: `irq_enable_reg`

## Requirements
- R1: `irq` is high exactly when some bit i has both `en_rdata[i]` and `status[i]` at 1. Bit positions are magic 0, system 1, transmit 2, transmit done 3, transmit start 4, software timer 5, receive 6.
- R2: When `wr_en` is high, each flag i with `wr_data[i]`=1 takes `wr_data[7]` (the value bit) at the clock edge. Every other flag keeps its state. With `wr_en` low, `wr_data` has no effect.
- R3: When `mask_wr` is high, `mask_wdata[0]` is the transmit mask: 1 clears flag 2 and 0 sets it. `mask_rdata[0]` always reads the inverse of flag 2.
- R4: When `mask_wr` is high, `mask_wdata[1]` is the receive mask: 1 clears flag 6 and 0 sets it. `mask_rdata[1]` always reads the inverse of flag 6.
- R5: A cycle with `hard_rst` high loads flags 6 and 2 with `cfg_preset` and clears all other flags.
- R6: A cycle with `soft_rst` high (and `hard_rst` low) sets flags 6 and 2 whatever `cfg_preset` is. All other flags keep their state, and every write in that cycle is ignored.
- R7: `als_wr[k]` writes `als_wdata[k]` without inversion into the flag that alias slot k maps to. The slot order is magic (k=0), system (1), transmit done (2), transmit start (3), software timer (4).
- R8: If a bitmap write selects a flag that a mask or alias write also targets in the same cycle, the bitmap value is stored.
- R9: `en_rdata[7]` is reserved and always reads 0, including after writes with the value bit set.
- R10: A flag change is visible on `en_rdata` and `irq` only after the clock edge that samples the write. Before that edge, `irq` still reflects the old flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hard_rst | input | 1 | Synchronous hard reset, active high |
| soft_rst | input | 1 | Synchronous soft reset, active high |
| cfg_preset | input | 1 | Configuration preset for receive/transmit flags at hard reset |
| wr_en | input | 1 | Bitmap write strobe |
| wr_data | input | 8 | [7] value bit, [6:0] bitmap |
| mask_wr | input | 1 | Mask view write strobe |
| mask_wdata | input | 2 | [1] receive mask, [0] transmit mask |
| mask_rdata | output | 2 | Mask view readback (inverted flags 6 and 2) |
| als_wr | input | 5 | Per-slot alias write strobes |
| als_wdata | input | 5 | Per-slot alias write values |
| status | input | 7 | Latched interrupt status bits |
| en_rdata | output | 8 | Flag readback, bit 7 reserved zero |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `hard_rst` is held during the first cycles. From that point on, every cycle must follow one of the cases they cover. A write-back property applies only when its own write path is the sole one active in a cycle without reset. Otherwise it relies on the priority order. The bench releases reset only at a falling edge and drives strobes for one cycle at a time, so each property sees a defined prior cycle. Conflicting writes are issued only in the dedicated priority test.

// File: rtl/irqen_pkg.sv
package irqen_pkg;
  localparam int unsigned EN_W   = 7;
  localparam int unsigned ALS_W  = 5;
  localparam int unsigned MASK_W = 2;
  localparam int unsigned WR_W   = EN_W + 1;
  localparam int unsigned V_BIT  = EN_W;

  localparam int unsigned B_MAGIC = 0;
  localparam int unsigned B_SYS   = 1;
  localparam int unsigned B_TX    = 2;
  localparam int unsigned B_TXDN  = 3;
  localparam int unsigned B_TXST  = 4;
  localparam int unsigned B_SWT   = 5;
  localparam int unsigned B_RX    = 6;

  localparam int unsigned M_TX = 0;
  localparam int unsigned M_RX = 1;

  typedef logic [EN_W-1:0] en_vec_t;

  localparam en_vec_t PAIR_MASK = en_vec_t'((1 << B_RX) | (1 << B_TX));

  function automatic int unsigned als_to_en(input int unsigned k);
    case (k)
      0:       return B_MAGIC;
      1:       return B_SYS;
      2:       return B_TXDN;
      3:       return B_TXST;
      default: return B_SWT;
    endcase
  endfunction
endpackage

// File: rtl/irqen_write_merge.sv
module irqen_write_merge
  import irqen_pkg::*;
(
  input  en_vec_t           cur,
  input  logic              wr_en,
  input  logic [WR_W-1:0]   wr_data,
  input  logic              mask_wr,
  input  logic [MASK_W-1:0] mask_wdata,
  input  logic [ALS_W-1:0]  als_wr,
  input  logic [ALS_W-1:0]  als_wdata,
  output en_vec_t           nxt
);
  en_vec_t alt_hit;
  en_vec_t alt_val;

  // Secondary paths: same-polarity aliases and inverted masks
  always_comb begin
    alt_hit = '0;
    alt_val = '0;
    for (int k = 0; k < ALS_W; k++) begin
      alt_hit[als_to_en(k)] = als_wr[k];
      alt_val[als_to_en(k)] = als_wdata[k];
    end
    alt_hit[B_TX] = mask_wr;
    alt_val[B_TX] = ~mask_wdata[M_TX];
    alt_hit[B_RX] = mask_wr;
    alt_val[B_RX] = ~mask_wdata[M_RX];
  end

  // Bitmap path has priority over the secondary paths
  for (genvar i = 0; i < EN_W; i++) begin : g_bit
    always_comb begin
      if (wr_en && wr_data[i])
        nxt[i] = wr_data[V_BIT];
      else if (alt_hit[i])
        nxt[i] = alt_val[i];
      else
        nxt[i] = cur[i];
    end
  end
endmodule

// File: rtl/irqen_store.sv
module irqen_store
  import irqen_pkg::*;
(
  input  logic    clk,
  input  logic    hard_rst,
  input  logic    soft_rst,
  input  logic    cfg_preset,
  input  en_vec_t nxt,
  output en_vec_t q
);
  en_vec_t hard_val;
  assign hard_val = cfg_preset ? PAIR_MASK : '0;

  always_ff @(posedge clk) begin
    if (hard_rst)
      q <= hard_val;
    else if (soft_rst)
      q <= q | PAIR_MASK;
    else
      q <= nxt;
  end
endmodule

// File: rtl/irqen_combine.sv
module irqen_combine
  import irqen_pkg::*;
(
  input  en_vec_t en,
  input  en_vec_t status,
  output logic    irq
);
  assign irq = |(en & status);
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg
  import irqen_pkg::*;
(
  input  logic              clk,
  input  logic              hard_rst,
  input  logic              soft_rst,
  input  logic              cfg_preset,
  input  logic              wr_en,
  input  logic [WR_W-1:0]   wr_data,
  input  logic              mask_wr,
  input  logic [MASK_W-1:0] mask_wdata,
  output logic [MASK_W-1:0] mask_rdata,
  input  logic [ALS_W-1:0]  als_wr,
  input  logic [ALS_W-1:0]  als_wdata,
  input  logic [EN_W-1:0]   status,
  output logic [WR_W-1:0]   en_rdata,
  output logic              irq
);
  en_vec_t en_q;
  en_vec_t en_nxt;

  irqen_write_merge u_merge (
    .cur(en_q), .wr_en(wr_en), .wr_data(wr_data),
    .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .als_wr(als_wr), .als_wdata(als_wdata), .nxt(en_nxt)
  );

  irqen_store u_store (
    .clk(clk), .hard_rst(hard_rst), .soft_rst(soft_rst),
    .cfg_preset(cfg_preset), .nxt(en_nxt), .q(en_q)
  );

  irqen_combine u_comb (
    .en(en_q), .status(status), .irq(irq)
  );

  assign en_rdata = {1'b0, en_q};
  assign mask_rdata[M_TX] = ~en_q[B_TX];
  assign mask_rdata[M_RX] = ~en_q[B_RX];
endmodule

// File: rtl/irqen_checker.sv
module irqen_checker
  import irqen_pkg::*;
(
  input logic              clk,
  input logic              hard_rst,
  input logic              soft_rst,
  input logic              cfg_preset,
  input logic              wr_en,
  input logic [WR_W-1:0]   wr_data,
  input logic              mask_wr,
  input logic [MASK_W-1:0] mask_wdata,
  input logic [ALS_W-1:0]  als_wr,
  input logic [EN_W-1:0]   status,
  input logic [WR_W-1:0]   en_rdata,
  input logic              irq
);
  logic idle;
  assign idle = !wr_en && !mask_wr && (als_wr == '0) && !soft_rst && !hard_rst;

  p_no_status_no_irq_r1: assert property (@(posedge clk) disable iff (hard_rst)
    (status == '0) |-> !irq);

  p_bitmap_write_r2: assert property (@(posedge clk) disable iff (hard_rst)
    (wr_en && !soft_rst) |=>
      ((en_rdata[EN_W-1:0] & $past(wr_data[EN_W-1:0])) ==
       ($past(wr_data[V_BIT]) ? $past(wr_data[EN_W-1:0]) : '0)));

  p_hold_when_idle_r2: assert property (@(posedge clk) disable iff (hard_rst)
    idle |=> $stable(en_rdata));

  p_tx_mask_write_r3: assert property (@(posedge clk) disable iff (hard_rst)
    (mask_wr && !wr_en && !soft_rst) |=> (en_rdata[B_TX] == !$past(mask_wdata[M_TX])));

  p_rx_mask_write_r4: assert property (@(posedge clk) disable iff (hard_rst)
    (mask_wr && !wr_en && !soft_rst) |=> (en_rdata[B_RX] == !$past(mask_wdata[M_RX])));

  p_hard_defaults_r5: assert property (@(posedge clk)
    hard_rst |=> (en_rdata[EN_W-1:0] == ($past(cfg_preset) ? PAIR_MASK : '0)));

  p_soft_defaults_r6: assert property (@(posedge clk) disable iff (hard_rst)
    soft_rst |=> (en_rdata[B_RX] && en_rdata[B_TX] &&
                  ((en_rdata[EN_W-1:0] & ~PAIR_MASK) == $past(en_rdata[EN_W-1:0] & ~PAIR_MASK))));
endmodule

bind irq_enable_reg irqen_checker i_chk (
  .clk(clk), .hard_rst(hard_rst), .soft_rst(soft_rst), .cfg_preset(cfg_preset),
  .wr_en(wr_en), .wr_data(wr_data), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
  .als_wr(als_wr), .status(status), .en_rdata(en_rdata), .irq(irq)
);

// File: tb/test_irq_enable_reg.sv
`timescale 1ns/1ps
module test_irq_enable_reg;
  logic       clk = 1'b0;
  logic       hard_rst, soft_rst, cfg_preset, wr_en, mask_wr, irq;
  logic [7:0] wr_data, en_rdata;
  logic [1:0] mask_wdata, mask_rdata;
  logic [4:0] als_wr, als_wdata;
  logic [6:0] status;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_enable_reg i_irq_enable_reg (
    .clk(clk), .hard_rst(hard_rst), .soft_rst(soft_rst), .cfg_preset(cfg_preset),
    .wr_en(wr_en), .wr_data(wr_data), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .mask_rdata(mask_rdata), .als_wr(als_wr), .als_wdata(als_wdata),
    .status(status), .en_rdata(en_rdata), .irq(irq)
  );

  // {wr_en, wr_data, status, expected flags, expected irq}
  localparam logic [23:0] TBL [8] = '{
    {1'b1, 8'hFF, 7'h00, 7'h7F, 1'b0},
    {1'b1, 8'h05, 7'h04, 7'h7A, 1'b0},
    {1'b1, 8'h00, 7'h02, 7'h7A, 1'b1},
    {1'b0, 8'hFF, 7'h01, 7'h7A, 1'b0},
    {1'b1, 8'h81, 7'h01, 7'h7B, 1'b1},
    {1'b1, 8'h7F, 7'h7F, 7'h00, 1'b0},
    {1'b1, 8'hC0, 7'h40, 7'h40, 1'b1},
    {1'b1, 8'h90, 7'h20, 7'h50, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    hard_rst = 0; soft_rst = 0; wr_en = 0; wr_data = '0; mask_wr = 0;
    mask_wdata = '0; als_wr = '0; als_wdata = '0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    hard_rst = 1; cfg_preset = 0; status = '0;
    @(negedge clk); step();
    hard_rst = 0;
    check("R5 reset flags, no preset", en_rdata, 8'h00);
    check("R1 reset irq", irq, 0);
    check("R3 R4 reset mask readback", mask_rdata, 2'b11);

    for (int i = 0; i < 8; i++) begin
      logic [23:0] v;
      v = TBL[i];
      wr_en = v[23]; wr_data = v[22:15]; status = v[14:8];
      step();
      check($sformatf("R2 table row %0d flags", i), en_rdata, {1'b0, v[7:1]});
      check($sformatf("R1 table row %0d irq", i), irq, v[0]);
    end
    idle_inputs();

    // R5: hard reset with preset clears others, sets rx/tx
    hard_rst = 1; cfg_preset = 1; step(); hard_rst = 0;
    check("R5 hard reset with preset", en_rdata, 8'h44);

    // R3/R4 mask views
    mask_wr = 1; mask_wdata = 2'b01; step();
    check("R3 tx mask set clears tx", en_rdata, 8'h40);
    check("R4 rx mask clear sets rx / readback", mask_rdata, 2'b01);
    mask_wdata = 2'b10; step(); mask_wr = 0;
    check("R4 rx mask set clears rx", en_rdata, 8'h04);
    check("R3 R4 mask readback", mask_rdata, 2'b10);

    // R7 aliases
    als_wr = 5'b11111; als_wdata = 5'b10101; step();
    check("R7 alias slot write", en_rdata, 8'h2D);
    als_wr = 5'b00010; als_wdata = 5'b00010; step();
    check("R7 alias system only", en_rdata, 8'h2F);

    // R8 priority
    wr_en = 1; wr_data = 8'h01; als_wr = 5'b00011; als_wdata = 5'b00001; step();
    check("R8 bitmap beats alias", en_rdata, 8'h2C);
    als_wr = '0; als_wdata = '0;
    wr_data = 8'hC0; mask_wr = 1; mask_wdata = 2'b11; step();
    check("R8 bitmap beats mask", en_rdata, 8'h68);
    idle_inputs();

    // R6 soft reset, writes ignored, preset irrelevant
    cfg_preset = 0; soft_rst = 1; wr_en = 1; wr_data = 8'h7F; step();
    idle_inputs();
    check("R6 soft reset defaults", en_rdata, 8'h6C);

    // R9 reserved bit
    wr_en = 1; wr_data = 8'hFF; step(); wr_en = 0;
    check("R9 reserved bit reads zero", en_rdata[7], 0);
    wr_en = 1; wr_data = 8'h7F; step(); wr_en = 0;
    check("R2 clear all", en_rdata, 8'h00);

    // R10 timing
    status = 7'h01; wr_en = 1; wr_data = 8'h81;
    #1;
    check("R10 irq before edge", irq, 0);
    step(); wr_en = 0;
    check("R10 irq after edge", irq, 1);
    check("R10 flags after edge", en_rdata, 8'h01);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule